// File: doc/BRIEF.md
# Byte-Lane Addressable Register File

This block holds four 16-bit general-purpose registers. Every access names a register with a 2-bit register code and a portion of it with a 2-bit size code. The portion is the whole word, the low byte (bits 7:0) or the high byte (bits 15:8). Size code 11 is reserved: it is not a data access, and the port that carries it raises its illegal flag.

There are two independent read ports and one write port. The read ports are combinational. They return the selected portion right-aligned and zero-extended to 16 bits. The write port is synchronous and updates only the selected byte lanes. A byte write takes its data from the low byte of the write data and leaves the other half of the register as it was. A reset clears every register. A read in the same cycle as a write to the same register sees the old contents.

Top module: `regbank_lanes`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero. Reads issued after the reset edge return zero.
- R2: The register code selects the register: 00 is register 0, 01 is register 1, 10 is register 2 and 11 is register 3. This holds on both read ports and on the write port.
- R3: Size code 00 is a word access. A read returns all 16 bits. A write stores all 16 bits of the write data.
- R4: Size code 01 is a low-byte access. A read returns register bits 7:0 on read data bits 7:0, with bits 15:8 zero. A write stores write data bits 7:0 into register bits 7:0 and keeps register bits 15:8.
- R5: Size code 10 is a high-byte access. A read returns register bits 15:8 on read data bits 7:0, with bits 15:8 zero. A write stores write data bits 7:0 into register bits 15:8 and keeps register bits 7:0.
- R6: Size code 11 drives that port's illegal flag high in the same cycle. Its read data is all zero. The flag is low for the other three codes.
- R7: A write with the write enable low, or with size code 11, leaves all four registers unchanged.
- R8: A read of a register that is being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R9: The two read ports work independently. Each uses its own register code and size code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 2 | Register code for the write |
| wr_size | input | 2 | Size code for the write |
| wr_data | input | 16 | Write data (bits 7:0 only for byte writes) |
| wr_illegal | output | 1 | Write size code is reserved |
| rd0_sel | input | 2 | Register code for read port 0 |
| rd0_size | input | 2 | Size code for read port 0 |
| rd0_data | output | 16 | Read port 0 data, right-aligned and zero-extended |
| rd0_illegal | output | 1 | Read port 0 size code is reserved |
| rd1_sel | input | 2 | Register code for read port 1 |
| rd1_size | input | 2 | Size code for read port 1 |
| rd1_data | output | 16 | Read port 1 data, right-aligned and zero-extended |
| rd1_illegal | output | 1 | Read port 1 size code is reserved |

## Verification
The read data and all three illegal flags are combinational. Each is due in the same cycle its codes are applied, so the bench compares them shortly before the next rising edge. A write shows up only through reads issued after the following rising edge. The bench's model therefore computes each cycle's read expectations from its register state before it applies that cycle's write. The reset check uses the same scheme: reads issued after the reset edge must return zero.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_LOW  = 2'b01,
    SZ_HIGH = 2'b10,
    SZ_RSVD = 2'b11
  } size_code_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/regbank_lane_decode.sv
module regbank_lane_decode
  import regbank_pkg::*;
(
  input  logic [1:0]       size,
  output logic [LANES-1:0] lane_mask,
  output logic             illegal
);

  always_comb begin
    lane_mask = '0;
    illegal   = 1'b0;
    case (size_code_e'(size))
      SZ_WORD: lane_mask = 2'b11;
      SZ_LOW:  lane_mask = 2'b01;
      SZ_HIGH: lane_mask = 2'b10;
      default: illegal   = 1'b1;
    endcase
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned LANE_W   = 8,
  localparam int unsigned DATA_W  = LANES * LANE_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 wr_sel,
  input  logic [LANES-1:0]                 lane_mask,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  bank
);

  logic word_write;
  assign word_write = &lane_mask;

  // Per-lane write data: a word write takes its own lane, a byte write
  // always sources the lowest lane of the input.
  logic [LANES-1:0][LANE_W-1:0] lane_src;
  for (genvar k = 0; k < LANES; k++) begin : g_src
    assign lane_src[k] = word_write ? wr_data[k*LANE_W +: LANE_W]
                                    : wr_data[LANE_W-1:0];
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(r));
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst) begin
          bank[r][k*LANE_W +: LANE_W] <= '0;
        end else if (hit && lane_mask[k]) begin
          bank[r][k*LANE_W +: LANE_W] <= lane_src[k];
        end
      end
    end

    // R1: a reset edge leaves this register at zero
    a_r1_reset_clears : assert property (@(posedge clk)
      rst |=> (bank[r] == '0));
  end

endmodule

// File: rtl/regbank_read_port.sv
module regbank_read_port
  import regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned LANE_W   = 8,
  localparam int unsigned DATA_W  = LANES * LANE_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  bank,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [1:0]                       size,
  output logic [DATA_W-1:0]                data,
  output logic                             illegal
);

  logic [LANES-1:0] mask;

  regbank_lane_decode u_dec (
    .size      (size),
    .lane_mask (mask),
    .illegal   (illegal)
  );

  logic [DATA_W-1:0] word;
  assign word = bank[sel];

  always_comb begin
    data = '0;
    case (mask)
      2'b11:   data = word;
      2'b01:   data = {{LANE_W{1'b0}}, word[LANE_W-1:0]};
      2'b10:   data = {{LANE_W{1'b0}}, word[DATA_W-1:LANE_W]};
      default: data = '0;
    endcase
  end

  // R6: a reserved size code returns no data
  a_r6_rsvd_read_zero : assert property (@(posedge clk) disable iff (rst)
    illegal |-> (data == '0));

  // R4 / R5: byte reads never drive the upper half
  a_r4_byte_read_upper_zero : assert property (@(posedge clk) disable iff (rst)
    (size != 2'b00) |-> (data[DATA_W-1:LANE_W] == '0));

endmodule

// File: rtl/regbank_lanes.sv
module regbank_lanes
  import regbank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned LANE_W   = 8,
  localparam int unsigned DATA_W  = LANES * LANE_W,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [SEL_W-1:0]  rd0_sel,
  input  logic [1:0]        rd0_size,
  output logic [DATA_W-1:0] rd0_data,
  output logic              rd0_illegal,
  input  logic [SEL_W-1:0]  rd1_sel,
  input  logic [1:0]        rd1_size,
  output logic [DATA_W-1:0] rd1_data,
  output logic              rd1_illegal
);

  logic [LANES-1:0]                wr_mask;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank;

  regbank_lane_decode u_wdec (
    .size      (wr_size),
    .lane_mask (wr_mask),
    .illegal   (wr_illegal)
  );

  regbank_store #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .lane_mask (wr_mask),
    .wr_data   (wr_data),
    .bank      (bank)
  );

  regbank_read_port #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) u_rd0 (
    .clk     (clk),
    .rst     (rst),
    .bank    (bank),
    .sel     (rd0_sel),
    .size    (rd0_size),
    .data    (rd0_data),
    .illegal (rd0_illegal)
  );

  regbank_read_port #(.NUM_REGS(NUM_REGS), .LANE_W(LANE_W)) u_rd1 (
    .clk     (clk),
    .rst     (rst),
    .bank    (bank),
    .sel     (rd1_sel),
    .size    (rd1_size),
    .data    (rd1_data),
    .illegal (rd1_illegal)
  );

  // R7: a disabled or reserved-size write changes nothing
  a_r7_no_write_effect : assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (wr_size == 2'b11)) |=> $stable(bank));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
    // R4: a low-byte write keeps the high byte and stores the data low byte
    a_r4_low_keeps_high : assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(r) && wr_size == 2'b01) |=>
        ($stable(bank[r][DATA_W-1:LANE_W]) &&
         bank[r][LANE_W-1:0] == $past(wr_data[LANE_W-1:0])));
    // R5: a high-byte write keeps the low byte and stores the data low byte
    a_r5_high_keeps_low : assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(r) && wr_size == 2'b10) |=>
        ($stable(bank[r][LANE_W-1:0]) &&
         bank[r][DATA_W-1:LANE_W] == $past(wr_data[LANE_W-1:0])));
    // R2: a write to another register leaves this one alone
    a_r2_other_reg_stable : assert property (@(posedge clk) disable iff (rst)
      (wr_sel != SEL_W'(r)) |=> $stable(bank[r]));
  end

endmodule

// File: tb/regbank_lanes_tb_top.sv
module regbank_lanes_tb_top;

  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0, wr_size = '0;
  logic [15:0] wr_data = '0;
  logic        wr_illegal;
  logic [1:0]  rd0_sel = '0, rd0_size = '0, rd1_sel = '0, rd1_size = '0;
  logic [15:0] rd0_data, rd1_data;
  logic        rd0_illegal, rd1_illegal;

  always #(HALF) clk = ~clk;

  regbank_lanes dut_i (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size), .wr_data(wr_data),
    .wr_illegal(wr_illegal),
    .rd0_sel(rd0_sel), .rd0_size(rd0_size), .rd0_data(rd0_data), .rd0_illegal(rd0_illegal),
    .rd1_sel(rd1_sel), .rd1_size(rd1_size), .rd1_data(rd1_data), .rd1_illegal(rd1_illegal)
  );

  typedef struct {
    int          port;   // 0 read0, 1 read1, 2 write flag
    logic [15:0] data;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] model [4];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  function automatic logic [15:0] ref_read(logic [1:0] s, logic [1:0] z);
    case (z)
      2'b00:   return model[s];
      2'b01:   return {8'h00, model[s][7:0]};
      2'b10:   return {8'h00, model[s][15:8]};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic step(input logic we, input logic [1:0] ws, input logic [1:0] wz,
                      input logic [15:0] wd,
                      input logic [1:0] s0, input logic [1:0] z0,
                      input logic [1:0] s1, input logic [1:0] z1,
                      input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_size = wz; wr_data = wd;
    rd0_sel = s0; rd0_size = z0; rd1_sel = s1; rd1_size = z1;
    e.tag = tag;
    e.port = 0; e.data = ref_read(s0, z0); e.ill = (z0 == 2'b11); sb.push_back(e);
    e.port = 1; e.data = ref_read(s1, z1); e.ill = (z1 == 2'b11); sb.push_back(e);
    e.port = 2; e.data = 16'h0;            e.ill = (wz == 2'b11); sb.push_back(e);
    // model takes the write at the coming edge
    if (we) begin
      case (wz)
        2'b00: model[ws] = wd;
        2'b01: model[ws][7:0]  = wd[7:0];
        2'b10: model[ws][15:8] = wd[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_size = 2'b00; wr_data = 16'hFFFF;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 4; i++) model[i] = 16'h0000;
  endtask

  // monitor: sample shortly before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(HALF - 2ns);
      while (sb.size() > 0) begin
        exp_t e;
        logic [15:0] ad;
        logic        ai;
        e = sb.pop_front();
        case (e.port)
          0:       begin ad = rd0_data; ai = rd0_illegal; end
          1:       begin ad = rd1_data; ai = rd1_illegal; end
          default: begin ad = 16'h0;    ai = wr_illegal;  end
        endcase
        n_chk++;
        if (ad !== e.data || ai !== e.ill) begin
          n_bad++;
          $display("FAIL %s port%0d: got data=%h ill=%b, want data=%h ill=%b",
                   e.tag, e.port, ad, ai, e.data, e.ill);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 16'h0000;
    do_reset();
    // R1: all registers read zero after reset
    step(0, 0, 0, 0, 2'd0, 2'b00, 2'd1, 2'b00, "R1");
    step(0, 0, 0, 0, 2'd2, 2'b00, 2'd3, 2'b00, "R1");
    // R2/R3: word writes to each register, distinct values
    step(1, 2'd0, 2'b00, 16'h1A2B, 2'd0, 2'b00, 2'd1, 2'b00, "R3");
    step(1, 2'd1, 2'b00, 16'h3C4D, 2'd0, 2'b00, 2'd1, 2'b00, "R3");
    step(1, 2'd2, 2'b00, 16'h5E6F, 2'd1, 2'b00, 2'd2, 2'b00, "R2");
    step(1, 2'd3, 2'b00, 16'h7081, 2'd2, 2'b00, 2'd3, 2'b00, "R2");
    step(0, 0, 0, 0, 2'd3, 2'b00, 2'd0, 2'b00, "R2");
    // R4: byte reads of the low lane, low-byte writes
    step(0, 0, 0, 0, 2'd0, 2'b01, 2'd3, 2'b01, "R4");
    step(1, 2'd1, 2'b01, 16'hEE99, 2'd1, 2'b00, 2'd1, 2'b01, "R4");
    step(0, 0, 0, 0, 2'd1, 2'b00, 2'd1, 2'b10, "R4");
    // R5: high lane reads and writes
    step(1, 2'd2, 2'b10, 16'hDDA5, 2'd2, 2'b10, 2'd2, 2'b01, "R5");
    step(0, 0, 0, 0, 2'd2, 2'b00, 2'd2, 2'b10, "R5");
    step(1, 2'd3, 2'b10, 16'h0042, 2'd3, 2'b00, 2'd0, 2'b10, "R5");
    step(0, 0, 0, 0, 2'd3, 2'b00, 2'd3, 2'b01, "R5");
    // R6: reserved size on each port
    step(0, 0, 2'b11, 0, 2'd0, 2'b11, 2'd1, 2'b00, "R6");
    step(0, 0, 0, 0, 2'd2, 2'b01, 2'd3, 2'b11, "R6");
    // R7: disabled and reserved-size writes
    step(0, 2'd0, 2'b00, 16'hBEEF, 2'd0, 2'b00, 2'd1, 2'b00, "R7");
    step(1, 2'd0, 2'b11, 16'hCAFE, 2'd0, 2'b00, 2'd2, 2'b00, "R7");
    step(0, 0, 0, 0, 2'd0, 2'b00, 2'd0, 2'b10, "R7");
    // R8: read during write sees the old value, then the new one
    step(1, 2'd1, 2'b00, 16'h9876, 2'd1, 2'b00, 2'd1, 2'b01, "R8");
    step(1, 2'd1, 2'b01, 16'h0011, 2'd1, 2'b00, 2'd1, 2'b10, "R8");
    step(0, 0, 0, 0, 2'd1, 2'b00, 2'd1, 2'b01, "R8");
    // R9: ports with different codes in a sweep
    for (int i = 0; i < 16; i++) begin
      step(1, 2'(i), 2'(i >> 2), 16'(16'h1357 * (i + 1)),
           2'(i + 1), 2'(i), 2'(3 - i), 2'(i >> 1), "R9");
    end
    // R1: reset clears data written earlier
    do_reset();
    step(0, 0, 0, 0, 2'd0, 2'b00, 2'd1, 2'b00, "R1");
    step(0, 0, 0, 0, 2'd2, 2'b00, 2'd3, 2'b00, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule